// File: doc/BRIEF.md
# Indexed-Remap Setup Sequencer

This block carries out the already-decoded fields of an indexed-remap setup operation. It owns four 32-bit shape registers and one 24-bit remap control register. Each shape register describes how one operand's element index is reordered. The control register records two things for each of five operand slots: which shape the slot uses, and whether remapping is enabled for it. The slots are three inputs (in0, in1, in2) and two outputs (out0, out1).

A one-cycle `start` pulse carries six fields: a 5-bit mask, a mode bit, a 5-bit index-register field, a dimension, an element width and a 2D flag.

- **Allocate mode (mode 0).** The whole register set is rebuilt. Every register is cleared, then each set mask bit in turn receives the next free shape. The shape number wraps after three, so a fifth slot shares shape 0.
- **Targeted mode (mode 1).** The mask names one slot and one shape, and nothing else is touched.

The work proceeds one mask bit per cycle in a private copy. The result is published to the outputs in a single edge, marked by a one-cycle `done`.

Top module: `idx_remap_setup`

## Requirements
- R1: After reset all four shape outputs and `ctrl` are zero, and `busy` and `done` are low.
- R2: In mode 0 the control register is rebuilt from zero. Set mask bits are visited from bit 0 to bit 4, and mask bit k belongs to slot k. The n-th visited set bit (n counted from 0) receives shape n mod 4. Its 2-bit select field `ctrl[2k+1:2k]` is set to that shape number, and its enable bit `ctrl[10+k]` is set. All other select fields, all other enable bits and `ctrl[23:15]` read zero.
- R3: A loaded shape word has bits [6:0] = {index field, 2'b00}, bits [11:7] = dimension, bits [13:12] = element width, bit 14 = 2D flag and bits [31:15] = zero. In mode 0 only the shapes that were handed out hold this word, and every other shape reads zero.
- R4: In mode 0 with mask 5'b11111, slot in0 and slot out1 both select shape 0, giving `ctrl` = 24'h007CE4.
- R5: In mode 1, mask[2:0] names the slot and mask[4:3] names the shape. Only that shape word, that slot's select field (set to mask[4:3]) and that slot's enable bit (set to 1) change. Every other bit keeps its value.
- R6: In mode 1 a slot number of 5, 6 or 7 writes nothing, yet `done` still pulses.
- R7: `start` is taken only while `busy` is low. Counting the accepting clock edge as edge 0, `busy` is high from edge 0 until edge 5 in mode 0, or until edge 1 in mode 1. `done` is high for exactly the one cycle following that final edge.
- R8: The outputs do not change at any edge while `busy` is high, except the final edge of the operation. At that edge every change appears together.
- R9: A `start` during `busy` is ignored. A `start` presented in the cycle in which `done` is high is accepted as a new operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation with the fields below |
| mask | input | 5 | Slot mask (mode 0) or slot/shape selector (mode 1) |
| mask_mode | input | 1 | 0 = allocate, 1 = targeted |
| idx_base | input | 5 | Index register field, extended with two zero low bits |
| dim | input | DIM_W (5) | Dimension field |
| elem_w | input | EW_W (2) | Element width field |
| two_d | input | 1 | 2D reorder flag |
| shape0 | output | 32 | Shape register 0 |
| shape1 | output | 32 | Shape register 1 |
| shape2 | output | 32 | Shape register 2 |
| shape3 | output | 32 | Shape register 3 |
| ctrl | output | 24 | Remap control register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the completion of one operation (`done` high, outputs just published) and the arrival of the next `start`. The bench provokes this by raising `start` in the very cycle it first sees `done`. It judges the case by checking that the second operation starts from the first one's published state and still has the full latency. The opposite overlap, a `start` arriving in the middle of a scan, is checked by showing that latency and final contents match the first operation alone.

// File: rtl/idx_remap_pkg.sv
package idx_remap_pkg;
  localparam int SLOTS    = 5;   // in0,in1,in2,out0,out1
  localparam int SHAPES   = 4;
  localparam int SEL_W    = $clog2(SHAPES);
  localparam int SHAPE_W  = 32;
  localparam int CTRL_W   = 24;
  localparam int EN_LSB   = SLOTS * SEL_W;
  localparam int BASE_W   = 5;
  localparam int REGNUM_W = BASE_W + 2;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_SCAN,
    SEQ_SINGLE
  } seq_state_e;
endpackage

// File: rtl/idx_remap_ctrl.sv
module idx_remap_ctrl
  import idx_remap_pkg::*;
#(
  parameter int NSLOT = SLOTS,
  localparam int IDX_W = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  output logic             load,
  output logic             step,
  output logic             commit,
  output logic [IDX_W-1:0] bit_idx,
  output logic             busy,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSLOT - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] bit_q, bit_d;
  logic             done_q;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    load    = 1'b0;
    step    = 1'b0;
    commit  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          load    = 1'b1;
          bit_d   = '0;
          state_d = mode ? SEQ_SINGLE : SEQ_SCAN;
        end
      end
      SEQ_SCAN: begin
        step = 1'b1;
        if (bit_q == LAST_IDX) begin
          commit  = 1'b1;
          state_d = SEQ_IDLE;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
      SEQ_SINGLE: begin
        step    = 1'b1;
        commit  = 1'b1;
        state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      bit_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= commit;
      if (load || step) bit_q <= bit_d;
    end
  end

  assign bit_idx = bit_q;
  assign busy    = (state_q != SEQ_IDLE);
  assign done    = done_q;

  a_r7_scan_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_SCAN) |-> (bit_q <= LAST_IDX));
  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/idx_remap_bank.sv
module idx_remap_bank
  import idx_remap_pkg::*;
#(
  parameter int DIM_W = 5,
  parameter int EW_W  = 2,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic                      step,
  input  logic                      commit,
  input  logic [IDX_W-1:0]          bit_idx,
  input  logic [SLOTS-1:0]          mask_i,
  input  logic                      mode_i,
  input  logic [BASE_W-1:0]         base_i,
  input  logic [DIM_W-1:0]          dim_i,
  input  logic [EW_W-1:0]           ew_i,
  input  logic                      twod_i,
  output logic [SHAPES*SHAPE_W-1:0] shape_o,
  output logic [CTRL_W-1:0]         ctrl_o
);
  localparam int DIM_LSB = REGNUM_W;
  localparam int EW_LSB  = DIM_LSB + DIM_W;
  localparam int TD_BIT  = EW_LSB + EW_W;

  logic [SLOTS-1:0]   mask_q;
  logic               mode_q;
  logic [SHAPE_W-1:0] word_q, word_in;
  logic [SEL_W-1:0]   alloc_q, alloc_d;
  logic [SHAPE_W-1:0] work_sh   [SHAPES];
  logic [SHAPE_W-1:0] work_sh_d [SHAPES];
  logic [SHAPE_W-1:0] vis_sh    [SHAPES];
  logic [CTRL_W-1:0]  work_ctrl, work_ctrl_d, vis_ctrl;
  logic [IDX_W-1:0]   tgt_slot;
  logic [SEL_W-1:0]   tgt_shape;

  always_comb begin
    word_in                      = '0;
    word_in[REGNUM_W-1:0]        = {base_i, 2'b00};
    word_in[DIM_LSB +: DIM_W]    = dim_i;
    word_in[EW_LSB +: EW_W]      = ew_i;
    word_in[TD_BIT]              = twod_i;
  end

  assign tgt_slot  = mask_q[IDX_W-1:0];
  assign tgt_shape = mask_q[SLOTS-1 -: SEL_W];

  always_comb begin
    work_sh_d   = work_sh;
    work_ctrl_d = work_ctrl;
    alloc_d     = alloc_q;
    if (load) begin
      alloc_d = '0;
      if (mode_i) begin
        work_sh_d   = vis_sh;
        work_ctrl_d = vis_ctrl;
      end else begin
        for (int s = 0; s < SHAPES; s++) work_sh_d[s] = '0;
        work_ctrl_d = '0;
      end
    end else if (step) begin
      if (!mode_q) begin
        if (mask_q[bit_idx]) begin
          work_sh_d[alloc_q]                          = word_q;
          work_ctrl_d[SEL_W*bit_idx +: SEL_W]         = alloc_q;
          work_ctrl_d[EN_LSB + bit_idx]               = 1'b1;
          alloc_d                                     = alloc_q + 1'b1;
        end
      end else if (tgt_slot < IDX_W'(SLOTS)) begin
        work_sh_d[tgt_shape]                          = word_q;
        work_ctrl_d[SEL_W*tgt_slot +: SEL_W]          = tgt_shape;
        work_ctrl_d[EN_LSB + tgt_slot]                = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      mode_q    <= 1'b0;
      word_q    <= '0;
      alloc_q   <= '0;
      work_ctrl <= '0;
      vis_ctrl  <= '0;
    end else begin
      if (load) begin
        mask_q <= mask_i;
        mode_q <= mode_i;
        word_q <= word_in;
      end
      if (load || step) begin
        alloc_q   <= alloc_d;
        work_ctrl <= work_ctrl_d;
      end
      if (commit) vis_ctrl <= work_ctrl_d;
    end
  end

  for (genvar g = 0; g < SHAPES; g++) begin : g_shape
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        work_sh[g] <= '0;
        vis_sh[g]  <= '0;
      end else begin
        if (load || step) work_sh[g] <= work_sh_d[g];
        if (commit)       vis_sh[g]  <= work_sh_d[g];
      end
    end
    assign shape_o[g*SHAPE_W +: SHAPE_W] = vis_sh[g];
  end

  assign ctrl_o = vis_ctrl;

  a_r2_enables_follow_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !mode_q) |=> (vis_ctrl[EN_LSB +: SLOTS] == mask_q));
  a_r4_wrap_shares_shape0: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !mode_q && (mask_q == '1)) |=>
      (vis_ctrl[SEL_W-1:0] == '0) && (vis_ctrl[SEL_W*(SLOTS-1) +: SEL_W] == '0));
  a_r6_bad_slot_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && mode_q && (tgt_slot >= IDX_W'(SLOTS))) |=> $stable(vis_ctrl) && $stable(shape_o));
endmodule

// File: rtl/idx_remap_setup.sv
module idx_remap_setup
  import idx_remap_pkg::*;
#(
  parameter int DIM_W = 5,
  parameter int EW_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [SLOTS-1:0]   mask,
  input  logic               mask_mode,
  input  logic [BASE_W-1:0]  idx_base,
  input  logic [DIM_W-1:0]   dim,
  input  logic [EW_W-1:0]    elem_w,
  input  logic               two_d,
  output logic [SHAPE_W-1:0] shape0,
  output logic [SHAPE_W-1:0] shape1,
  output logic [SHAPE_W-1:0] shape2,
  output logic [SHAPE_W-1:0] shape3,
  output logic [CTRL_W-1:0]  ctrl,
  output logic               busy,
  output logic               done
);
  localparam int IDX_W = $clog2(SLOTS);

  logic                      load, step, commit;
  logic [IDX_W-1:0]          bit_idx;
  logic [SHAPES*SHAPE_W-1:0] shapes;

  idx_remap_ctrl #(.NSLOT(SLOTS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mode    (mask_mode),
    .load    (load),
    .step    (step),
    .commit  (commit),
    .bit_idx (bit_idx),
    .busy    (busy),
    .done    (done)
  );

  idx_remap_bank #(.DIM_W(DIM_W), .EW_W(EW_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .commit  (commit),
    .bit_idx (bit_idx),
    .mask_i  (mask),
    .mode_i  (mask_mode),
    .base_i  (idx_base),
    .dim_i   (dim),
    .ew_i    (elem_w),
    .twod_i  (two_d),
    .shape_o (shapes),
    .ctrl_o  (ctrl)
  );

  assign shape0 = shapes[0*SHAPE_W +: SHAPE_W];
  assign shape1 = shapes[1*SHAPE_W +: SHAPE_W];
  assign shape2 = shapes[2*SHAPE_W +: SHAPE_W];
  assign shape3 = shapes[3*SHAPE_W +: SHAPE_W];

  a_r8_publish_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done || $stable({shape0, shape1, shape2, shape3, ctrl})));
  a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

// File: tb/idx_remap_setup_test.sv
module idx_remap_setup_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [4:0]  mask;
  logic        mask_mode;
  logic [4:0]  idx_base;
  logic [4:0]  dim;
  logic [1:0]  elem_w;
  logic        two_d;
  logic [31:0] shape0, shape1, shape2, shape3;
  logic [23:0] ctrl;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_sh [4];
  logic [23:0] exp_ctrl;

  always #4 clk = ~clk;

  idx_remap_setup uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mask(mask), .mask_mode(mask_mode),
    .idx_base(idx_base), .dim(dim), .elem_w(elem_w), .two_d(two_d),
    .shape0(shape0), .shape1(shape1), .shape2(shape2), .shape3(shape3),
    .ctrl(ctrl), .busy(busy), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] shape_word(input logic [4:0] b, input logic [4:0] d,
                                              input logic [1:0] e, input logic t);
    return {17'b0, t, e, d, b, 2'b00};
  endfunction

  // expected state per R2..R6
  task automatic model(input logic [4:0] m, input logic md, input logic [31:0] w);
    if (!md) begin
      int n = 0;
      for (int s = 0; s < 4; s++) exp_sh[s] = '0;
      exp_ctrl = '0;
      for (int k = 0; k < 5; k++) begin
        if (m[k]) begin
          exp_sh[n % 4] = w;
          exp_ctrl[2*k +: 2] = 2'(n % 4);
          exp_ctrl[10+k] = 1'b1;
          n++;
        end
      end
    end else if (m[2:0] <= 3'd4) begin
      exp_sh[m[4:3]] = w;
      exp_ctrl[2*m[2:0] +: 2] = m[4:3];
      exp_ctrl[10+m[2:0]] = 1'b1;
    end
  endtask

  task automatic compare_all(input string req);
    check({req, " ctrl"}, {8'b0, ctrl}, {8'b0, exp_ctrl});
    check({req, "/R3 shape0"}, shape0, exp_sh[0]);
    check({req, "/R3 shape1"}, shape1, exp_sh[1]);
    check({req, "/R3 shape2"}, shape2, exp_sh[2]);
    check({req, "/R3 shape3"}, shape3, exp_sh[3]);
  endtask

  // Called at a negedge; optional spurious start at cycle 2 (R9).
  task automatic run_op(input logic [4:0] m, input logic md, input logic [4:0] b,
                        input logic [4:0] d, input logic [1:0] e, input logic t,
                        input bit poke, input string req);
    int k = 0;
    bit held = 1;
    logic [23:0] old_ctrl = ctrl;
    logic [31:0] old0 = shape0;
    start = 1'b1; mask = m; mask_mode = md; idx_base = b; dim = d; elem_w = e; two_d = t;
    @(negedge clk);
    start = 1'b0;
    check("R7 busy after accept", {31'b0, busy}, 32'd1);
    while (k < 20) begin
      if (poke && k == 1) begin
        start = 1'b1; mask = ~m; mask_mode = ~md; idx_base = ~b;
      end else if (poke && k == 2) begin
        start = 1'b0;
      end
      @(negedge clk);
      k++;
      if (done) break;
      if (ctrl !== old_ctrl || shape0 !== old0) held = 0;
    end
    check("R8 outputs held until done", {31'b0, held}, 32'd1);
    check("R7 latency", k, md ? 32'd1 : 32'd5);
    check("R7 busy low with done", {31'b0, busy}, 32'd0);
    model(m, md, shape_word(b, d, e, t));
    compare_all(req);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mask = '0; mask_mode = 1'b0;
    idx_base = '0; dim = '0; elem_w = '0; two_d = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ctrl", {8'b0, ctrl}, 32'd0);
    check("R1 shapes", shape0 | shape1 | shape2 | shape3, 32'd0);
    check("R1 busy/done", {30'b0, busy, done}, 32'd0);
    for (int s = 0; s < 4; s++) exp_sh[s] = '0;
    exp_ctrl = '0;

    // R2: in1 -> shape0, in2 -> shape1
    run_op(5'b00110, 1'b0, 5'd3, 5'd7, 2'd1, 1'b1, 0, "R2 mask00110");
    check("R2 literal", {8'b0, ctrl}, 32'h001810);
    // R2: in0 -> shape0, out1 -> shape1
    run_op(5'b10001, 1'b0, 5'd31, 5'd2, 2'd3, 1'b0, 0, "R2 mask10001");
    check("R2 literal b", {8'b0, ctrl}, 32'h004500);
    // R4 wraparound
    run_op(5'b11111, 1'b0, 5'd9, 5'd31, 2'd2, 1'b1, 0, "R4 all bits");
    check("R4 literal", {8'b0, ctrl}, 32'h007CE4);
    // R5 targeted: out0 -> shape2
    run_op(5'b10011, 1'b1, 5'd1, 5'd4, 2'd0, 1'b0, 0, "R5 out0 shape2");
    // R5 targeted: out1 -> shape3
    run_op(5'b11100, 1'b1, 5'd20, 5'd11, 2'd1, 1'b1, 0, "R5 out1 shape3");
    // R6 bad slot numbers change nothing
    run_op(5'b01101, 1'b1, 5'd5, 5'd5, 2'd2, 1'b0, 0, "R6 slot5");
    run_op(5'b11111, 1'b1, 5'd6, 5'd6, 2'd3, 1'b1, 0, "R6 slot7");
    // R2 empty mask clears everything
    run_op(5'b00000, 1'b0, 5'd8, 5'd8, 2'd1, 1'b1, 0, "R2 empty");
    // R9 start during busy ignored
    run_op(5'b01010, 1'b0, 5'd12, 5'd3, 2'd2, 1'b0, 1, "R9 ignore mid-scan");
    @(negedge clk);
    check("R9 no extra op", {31'b0, busy}, 32'd0);
    // R9 back-to-back: start in the done cycle
    run_op(5'b00001, 1'b0, 5'd17, 5'd9, 2'd0, 1'b1, 0, "R9 first");
    run_op(5'b00100, 1'b1, 5'd22, 5'd1, 2'd3, 1'b0, 0, "R9 back-to-back");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule